// File: doc/BRIEF.md
# Masked Vector Multiply-Add Lane Array

This block applies an integer multiply-add to every element of one 128-bit vector register in a single operation. The caller supplies the old destination vector, a second vector source, and either a third vector or a scalar that is copied to every element. It also supplies the mask register, a mask-enable bit, the element width, the active length and the two policy bits. The block returns the new destination vector. Two forms are offered. In the first, the destination is the addend: it is added to the product of the two sources. In the second, the destination is the multiplicand: it is multiplied by the operand and then the other source is added.

Elements at or beyond the active length are tail elements. Body elements whose mask bit is clear are inactive. Neither kind is computed. Each one either keeps its old value or is filled with all ones, as its policy bit selects. Results wrap at the element width and never raise a flag. An operation is launched with a one-cycle `start`. Two clock edges later the registered result appears and `done` pulses.

Top module: `vec_madd_lanes`

## Requirements
- R1: With `form_sel`=0, each active element becomes `vd + vs2*op`, keeping only the low SEW bits of both the product and the sum.
- R2: With `form_sel`=1, each active element becomes `vd*op + vs2`, keeping only the low SEW bits.
- R3: With `use_scalar`=1, `op` is the low SEW bits of `scalar_in` for every element. With `use_scalar`=0, `op` is element i of `src_b`.
- R4: `sew_sel` encodes the element width as 0=8, 1=16, 2=32 and 3=64 bits. Element i occupies bits [i*SEW +: SEW] of every vector, and there are 128/SEW elements.
- R5: With `mask_en_n`=1 every body element is active. With `mask_en_n`=0, body element i is active only when `mask_bits[i]` is 1.
- R6: An inactive body element keeps its old `vd` value when `ma_fill`=0, and becomes all ones when `ma_fill`=1.
- R7: An element with index at or above `vl` is tail, whatever its mask bit. It keeps its old value when `ta_fill`=0 and becomes all ones when `ta_fill`=1. A `vl` at or above the element count leaves no tail.
- R8: With `vl`=0, the result equals the old `vd` under every policy setting.
- R9: Inputs are sampled at the clock edge where `start` is 1. `result` and a one-cycle `done` appear two edges later. A `start` may be given on every cycle.
- R10: `result` keeps its value between `done` pulses.
- R11: During reset, `done` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation with the current inputs |
| form_sel | input | 1 | 0: the destination is the addend; 1: the destination is the multiplicand |
| use_scalar | input | 1 | 1: broadcast `scalar_in` as the operand |
| mask_en_n | input | 1 | 1: unmasked; 0: use `mask_bits` |
| ta_fill | input | 1 | Tail policy (1 = fill with ones) |
| ma_fill | input | 1 | Inactive-element policy (1 = fill with ones) |
| sew_sel | input | 2 | Element width code |
| vl | input | 5 | Active vector length (0 to 16) |
| mask_bits | input | 16 | Per-element mask, where bit i belongs to element i |
| old_vd | input | 128 | Old destination vector |
| src_a | input | 128 | Vector source (vs2) |
| src_b | input | 128 | Second vector operand (vs1) |
| scalar_in | input | 64 | Scalar operand |
| result | output | 128 | New destination vector |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench targets the following corner cases and the fault each one would expose:
- **Wraparound:** operands whose products and sums overflow at every width. A design that carried bits into the neighbouring element, or that computed at 64 bits whatever the width, would give wrong low bits.
- **Scalar truncation:** a scalar whose upper bits are set. This exposes a design that skips truncation.
- **Sparse masks under both policies:** this exposes swapped or ignored fill bits.
- **Tail with every mask bit clear:** this catches a design that lets the mask decide on tail elements.
- **`vl`=0 with both fills set:** this catches a design that fills the whole vector with ones.
- **Back-to-back launches:** these show a pipeline that drops or merges operations.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  typedef enum logic [1:0] {
    SEW8  = 2'd0,
    SEW16 = 2'd1,
    SEW32 = 2'd2,
    SEW64 = 2'd3
  } sew_e;

  typedef struct packed {
    logic form_sel;
    logic use_scalar;
    logic mask_en_n;
    logic ta_fill;
    logic ma_fill;
    sew_e sew;
  } ctl_t;
endpackage

// File: rtl/vmac_elem.sv
module vmac_elem #(
  parameter int W = 8
) (
  input  logic         form_sel,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mul_a,
  input  logic [W-1:0] op,
  output logic [W-1:0] res
);
  always_comb begin
    if (form_sel) res = acc * op + mul_a;
    else          res = acc + mul_a * op;
  end
endmodule

// File: rtl/vmac_width_unit.sv
module vmac_width_unit #(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  parameter int W    = 8,
  parameter int VLW  = 5
) (
  input  logic                 form_sel,
  input  logic                 use_scalar,
  input  logic                 mask_en_n,
  input  logic                 ta_fill,
  input  logic                 ma_fill,
  input  logic [VLW-1:0]       vl,
  input  logic [VLEN/W-1:0]    mask_bits,
  input  logic [VLEN-1:0]      vd,
  input  logic [VLEN-1:0]      va,
  input  logic [VLEN-1:0]      vb,
  input  logic [XLEN-1:0]      scalar_in,
  output logic [VLEN-1:0]      vout
);
  localparam int N = VLEN / W;

  logic [W-1:0] sc_trunc;
  assign sc_trunc = W'(scalar_in);

  for (genvar g = 0; g < N; g++) begin : g_elem
    localparam logic [VLW-1:0] IDX = VLW'(g);
    logic [W-1:0] op_e, res_e, old_e;
    logic         in_body, active;

    assign old_e   = vd[g*W +: W];
    assign op_e    = use_scalar ? sc_trunc : vb[g*W +: W];
    assign in_body = IDX < vl;
    assign active  = mask_en_n | mask_bits[g];

    vmac_elem #(.W(W)) u_elem (
      .form_sel (form_sel),
      .acc      (old_e),
      .mul_a    (va[g*W +: W]),
      .op       (op_e),
      .res      (res_e)
    );

    always_comb begin
      if (!in_body)     vout[g*W +: W] = ta_fill ? {W{1'b1}} : old_e;
      else if (!active) vout[g*W +: W] = ma_fill ? {W{1'b1}} : old_e;
      else              vout[g*W +: W] = res_e;
    end
  end
endmodule

// File: rtl/vec_madd_lanes.sv
module vec_madd_lanes #(
  parameter int VLEN = 128,
  parameter int XLEN = 64,
  localparam int MW  = VLEN / 8,
  localparam int VLW = $clog2(MW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            form_sel,
  input  logic            use_scalar,
  input  logic            mask_en_n,
  input  logic            ta_fill,
  input  logic            ma_fill,
  input  logic [1:0]      sew_sel,
  input  logic [VLW-1:0]  vl,
  input  logic [MW-1:0]   mask_bits,
  input  logic [VLEN-1:0] old_vd,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [XLEN-1:0] scalar_in,
  output logic [VLEN-1:0] result,
  output logic            done
);
  import vmac_pkg::*;

  localparam int NW = 4;

  // stage 1: operand capture
  logic            s1_valid, s1_valid_nx;
  ctl_t            s1_ctl, s1_ctl_nx;
  logic [VLW-1:0]  s1_vl, s1_vl_nx;
  logic [MW-1:0]   s1_mask, s1_mask_nx;
  logic [VLEN-1:0] s1_vd, s1_vd_nx, s1_va, s1_va_nx, s1_vb, s1_vb_nx;
  logic [XLEN-1:0] s1_sc, s1_sc_nx;

  // stage 2: result
  logic [VLEN-1:0] res_q, res_nx, sel_out;
  logic            done_q;

  logic [VLEN-1:0] unit_out [NW];

  always_comb begin
    s1_valid_nx = start;
    s1_ctl_nx   = s1_ctl;
    s1_vl_nx    = s1_vl;
    s1_mask_nx  = s1_mask;
    s1_vd_nx    = s1_vd;
    s1_va_nx    = s1_va;
    s1_vb_nx    = s1_vb;
    s1_sc_nx    = s1_sc;
    if (start) begin
      s1_ctl_nx   = '{form_sel: form_sel, use_scalar: use_scalar,
                      mask_en_n: mask_en_n, ta_fill: ta_fill,
                      ma_fill: ma_fill, sew: sew_e'(sew_sel)};
      s1_vl_nx    = vl;
      s1_mask_nx  = mask_bits;
      s1_vd_nx    = old_vd;
      s1_va_nx    = src_a;
      s1_vb_nx    = src_b;
      s1_sc_nx    = scalar_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ctl   <= '0;
      s1_vl    <= '0;
      s1_mask  <= '0;
      s1_vd    <= '0;
      s1_va    <= '0;
      s1_vb    <= '0;
      s1_sc    <= '0;
    end else begin
      s1_valid <= s1_valid_nx;
      s1_ctl   <= s1_ctl_nx;
      s1_vl    <= s1_vl_nx;
      s1_mask  <= s1_mask_nx;
      s1_vd    <= s1_vd_nx;
      s1_va    <= s1_va_nx;
      s1_vb    <= s1_vb_nx;
      s1_sc    <= s1_sc_nx;
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_width
    localparam int W = 8 << k;
    vmac_width_unit #(.VLEN(VLEN), .XLEN(XLEN), .W(W), .VLW(VLW)) u_unit (
      .form_sel   (s1_ctl.form_sel),
      .use_scalar (s1_ctl.use_scalar),
      .mask_en_n  (s1_ctl.mask_en_n),
      .ta_fill    (s1_ctl.ta_fill),
      .ma_fill    (s1_ctl.ma_fill),
      .vl         (s1_vl),
      .mask_bits  (s1_mask[VLEN/W-1:0]),
      .vd         (s1_vd),
      .va         (s1_va),
      .vb         (s1_vb),
      .scalar_in  (s1_sc),
      .vout       (unit_out[k])
    );
  end

  always_comb begin
    sel_out = (s1_vl == '0) ? s1_vd : unit_out[s1_ctl.sew];
    res_nx  = s1_valid ? sel_out : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_nx;
      done_q <= s1_valid;
    end
  end

  assign result = res_q;
  assign done   = done_q;

  // R9
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> s1_valid);
  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> done);
  // R9
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(s1_valid));
  // R8
  vl_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_vl == '0) |=> result == $past(s1_vd));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(result));
endmodule

// File: tb/vec_madd_lanes_test.sv
module vec_madd_lanes_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, form_sel, use_scalar, mask_en_n, ta_fill, ma_fill;
  logic [1:0]   sew_sel;
  logic [4:0]   vl;
  logic [15:0]  mask_bits;
  logic [127:0] old_vd, src_a, src_b;
  logic [63:0]  scalar_in;
  logic [127:0] result;
  logic         done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference pipeline state
  bit           m_s1v = 0, m_done = 0;
  logic [127:0] m_s1exp = '0, m_res = '0;
  string        m_s1tag = "", m_tag = "";
  string        cur_tag = "";

  always #2.5 clk = ~clk;

  vec_madd_lanes uut (
    .clk(clk), .rst_n(rst_n), .start(start), .form_sel(form_sel),
    .use_scalar(use_scalar), .mask_en_n(mask_en_n), .ta_fill(ta_fill),
    .ma_fill(ma_fill), .sew_sel(sew_sel), .vl(vl), .mask_bits(mask_bits),
    .old_vd(old_vd), .src_a(src_a), .src_b(src_b), .scalar_in(scalar_in),
    .result(result), .done(done)
  );

  function automatic logic [127:0] ref_calc();
    int w = 8 << sew_sel;
    int n = 128 / w;
    logic [127:0] mw, a, b, c, r, e, o;
    mw = (w == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << w) - 1);
    if (vl == 0) return old_vd;
    o = '0;
    for (int i = 0; i < n; i++) begin
      a = (old_vd >> (i * w)) & mw;
      b = (src_a >> (i * w)) & mw;
      c = use_scalar ? ({64'd0, scalar_in} & mw) : ((src_b >> (i * w)) & mw);
      r = form_sel ? ((a * c + b) & mw) : ((a + b * c) & mw);
      if (i >= int'(vl))                  e = ta_fill ? mw : a;
      else if (!mask_en_n && !mask_bits[i]) e = ma_fill ? mw : a;
      else                                e = r;
      o = o | (e << (i * w));
    end
    return o;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic cycle();
    @(posedge clk);
    #1;
    m_done = m_s1v;
    if (m_s1v) begin
      m_res = m_s1exp;
      m_tag = m_s1tag;
    end
    m_s1v = start;
    if (start) begin
      m_s1exp = ref_calc();
      m_s1tag = cur_tag;
    end
    checks++;
    if (done !== m_done) begin
      failures++;
      $display("FAIL R9 done actual=%0b expected=%0b", done, m_done);
    end
    checks++;
    if (result !== m_res) begin
      failures++;
      $display("FAIL %s result actual=%h expected=%h",
               m_done ? m_tag : "R10", result, m_res);
    end
  endtask

  task automatic launch(string tag, bit fm, bit us, bit men, bit ta, bit ma,
                        logic [1:0] sw, logic [4:0] l, logic [15:0] mk,
                        logic [127:0] vd, logic [127:0] va, logic [127:0] vb,
                        logic [63:0] sc);
    cur_tag = tag;
    form_sel = fm; use_scalar = us; mask_en_n = men; ta_fill = ta; ma_fill = ma;
    sew_sel = sw; vl = l; mask_bits = mk; old_vd = vd; src_a = va; src_b = vb;
    scalar_in = sc; start = 1'b1;
    cycle();
    start = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 0; form_sel = 0; use_scalar = 0; mask_en_n = 1;
    ta_fill = 0; ma_fill = 0; sew_sel = 0; vl = 0; mask_bits = 0;
    old_vd = '0; src_a = '0; src_b = '0; scalar_in = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    checks++;
    if (done !== 1'b0 || result !== '0) begin
      failures++;
      $display("FAIL R11 actual=%0b/%h expected=0/0", done, result);
    end
    rst_n = 1'b1;
    idle(2);

    // R1 addend form, wrapping 32-bit products
    launch("R1", 0, 0, 1, 0, 0, 2'd2, 5'd4, 16'h0, rnd128(),
           {4{32'hFFFF_FFF3}}, {4{32'h8000_0007}}, 64'd0);
    idle(3);
    // R2 multiplicand form, 16-bit
    launch("R2", 1, 0, 1, 0, 0, 2'd1, 5'd8, 16'h0, rnd128(), rnd128(), rnd128(), 64'd0);
    idle(3);
    // R3 scalar with upper bits set, 8-bit
    launch("R3", 0, 1, 1, 0, 0, 2'd0, 5'd16, 16'h0, rnd128(), rnd128(), rnd128(),
           64'hDEAD_BEEF_1234_56A5);
    idle(3);
    // R4 64-bit elements, scalar full width
    launch("R4", 1, 1, 1, 0, 0, 2'd3, 5'd2, 16'h0, rnd128(), rnd128(), rnd128(),
           {$urandom, $urandom});
    idle(3);
    // R5 sparse mask, undisturbed inactive
    launch("R5", 0, 0, 0, 0, 0, 2'd0, 5'd16, 16'hA53C, rnd128(), rnd128(), rnd128(), 64'd0);
    idle(3);
    // R6 inactive filled with ones
    launch("R6", 0, 1, 0, 0, 1, 2'd1, 5'd8, 16'h0069, rnd128(), rnd128(), rnd128(), 64'h3);
    idle(3);
    // R7 tail fill, mask all clear in tail
    launch("R7", 0, 0, 0, 1, 0, 2'd2, 5'd3, 16'h0007, rnd128(), rnd128(), rnd128(), 64'd0);
    idle(3);
    // R7 tail undisturbed, fills on inactive
    launch("R7", 1, 0, 1, 0, 1, 2'd0, 5'd5, 16'h0, rnd128(), rnd128(), rnd128(), 64'd0);
    idle(3);
    // R7 vl beyond element count leaves no tail
    launch("R7", 0, 0, 1, 1, 1, 2'd2, 5'd16, 16'h0, rnd128(), rnd128(), rnd128(), 64'd0);
    idle(3);
    // R8 vl zero under all-ones policies
    launch("R8", 0, 0, 0, 1, 1, 2'd0, 5'd0, 16'h0, rnd128(), rnd128(), rnd128(), 64'd0);
    idle(3);
    // R9 back-to-back launches of mixed widths
    for (int j = 0; j < 8; j++)
      launch("R9", j[0], j[1], j[2], j[0], j[1], 2'(j), 5'(1 + j * 2), 16'($urandom),
             rnd128(), rnd128(), rnd128(), {$urandom, $urandom});
    idle(4);
    // R10 hold across idle cycles while inputs change
    old_vd = rnd128(); src_a = rnd128();
    idle(4);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule